// File: doc/BRIEF.md
# Quadrature NCO Mixer

This block moves a real, signed intermediate-frequency sample stream to complex baseband. It contains a numerically controlled oscillator: a phase register that advances by a programmable tuning word once per accepted sample, and a waveform table that turns the upper phase bits into sine and cosine values. Each accepted sample is multiplied by the cosine to give the in-phase output and by the sine to give the quadrature output. The products are rounded, clipped and presented with a valid strobe.

The block sits between a sample source and a decimating low-pass filter. A sample is accepted on any clock edge where its valid strobe is high. The tuning word can be rewritten at any time. Out of reset it is preset so that the oscillator sits at a 70 MHz centre for a 250 MHz sample clock. Both channels pass through the same table read, multiply and rounding stages, so their relative phase is exact and their latency is equal.

Top module: `quad_nco_mixer`

## Requirements
- R1: While `rst_ni` is low, `iq_vld_o`, `i_o` and `q_o` are zero. The phase register clears to zero, so the first accepted sample after reset uses phase 0.
- R2: The phase register is 32 bits and wraps modulo 2^32. It advances by the current tuning word only on edges where `smp_vld_i` is high. It holds on all other edges.
- R3: Waveform table entry for a 10-bit address a: round(32767 * sin(2*pi*(a + 0.5)/1024)), with halves rounded away from zero. Only a quarter period is stored; the other three quarters come from mirroring the address and negating the value.
- R4: For a sample accepted with phase p, let a = p[31:22]. Q is the sample times the table entry at a. I is the sample times the entry at (a + 256) mod 1024, a quarter turn ahead (the cosine).
- R5: Each 31-bit product is scaled by 2^-15 with round-half-up (add 2^14, then arithmetic shift right by 15). The result is clipped to the signed 16-bit range. A zero sample gives zero on both outputs.
- R6: `iq_vld_o` equals `smp_vld_i` delayed by exactly four clock edges. Each result appears on the edge where its strobe rises.
- R7: The tuning word resets to 1202590843 (70 MHz at 250 MHz). A write with `fcw_we_i` high loads `fcw_i` at that edge. A sample accepted on the same edge still advances by the old word; the next accepted sample reflects the new word.
- R8: Between strobes, `i_o` and `q_o` keep the last result. Tuning-word writes and idle cycles do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_vld_i | input | 1 | Input sample is valid this edge |
| smp_i | input | 16 | Signed IF sample |
| fcw_we_i | input | 1 | Load a new tuning word |
| fcw_i | input | 32 | Tuning word (phase step per accepted sample) |
| iq_vld_o | output | 1 | I/Q result valid |
| i_o | output | 16 | Signed in-phase result |
| q_o | output | 16 | Signed quadrature result |

## Verification
A tuning step of one table address per sample walks every quadrant boundary. A design that folded the quarter table wrongly would show a sign flip or a doubled entry at the quarter points; a wrong cosine offset would swap or negate I against Q.

Full-scale samples of both signs check the rounding direction and the clipping. An off-by-one rounding constant would shift these results by one count.

Tuning-word writes are placed on the same edge as a sample, and phase steps are chosen to cross the 2^32 wrap. This exposes a word that takes effect one sample early or late. Idle gaps in the strobe catch a phase register that advances on every clock instead of every accepted sample. Long random runs with random strobes compare every result against a floating-point sine model.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // quadrant of the 10-bit table address (top two bits)
  typedef enum logic [1:0] {
    QD_RISE     = 2'd0,
    QD_FALL     = 2'd1,
    QD_NEG_FALL = 2'd2,
    QD_NEG_RISE = 2'd3
  } quadrant_e;

  // half-step offset keeps the quarter table free of the zero and peak points
  function automatic int quarter_amp(input int idx, input int n_full, input int amp_max);
    real x;
    x = real'(amp_max) * $sin(TWO_PI * (real'(idx) + 0.5) / real'(n_full));
    return $rtoi(x + 0.5);
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int                 PHASE_W = 32,
  parameter logic [PHASE_W-1:0] DEF_FCW = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic               fcw_we_i,
  input  logic [PHASE_W-1:0] fcw_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic [PHASE_W-1:0] fcw_o
);

  logic [PHASE_W-1:0] acc_q;
  logic [PHASE_W-1:0] fcw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      fcw_q <= DEF_FCW;
    end else begin
      if (step_i)   acc_q <= acc_q + fcw_q;
      if (fcw_we_i) fcw_q <= fcw_i;
    end
  end

  assign phase_o = acc_q;
  assign fcw_o   = fcw_q;

endmodule

// File: rtl/nco_quarter_lut.sv
module nco_quarter_lut #(
  parameter int ADDR_W = 10,
  parameter int AMP_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [ADDR_W-1:0]       sin_addr_i,
  output logic signed [AMP_W-1:0] sin_o,
  output logic signed [AMP_W-1:0] cos_o
);
  import nco_mix_pkg::*;

  localparam int IDX_W   = ADDR_W - 2;
  localparam int QN      = 2 ** IDX_W;
  localparam int N_FULL  = 2 ** ADDR_W;
  localparam int AMP_MAX = 2 ** (AMP_W - 1) - 1;

  logic [AMP_W-1:0] qtab [QN];

  for (genvar j = 0; j < QN; j++) begin : g_tab
    assign qtab[j] = AMP_W'(quarter_amp(j, N_FULL, AMP_MAX));
  end

  function automatic logic signed [AMP_W-1:0] fold(input logic [ADDR_W-1:0] a);
    quadrant_e        qd;
    logic [IDX_W-1:0] idx;
    logic [AMP_W-1:0] mag;
    qd  = quadrant_e'(a[ADDR_W-1 -: 2]);
    idx = a[IDX_W-1:0];
    if (qd == QD_FALL || qd == QD_NEG_RISE) idx = ~idx;
    mag = qtab[idx];
    if (qd == QD_NEG_FALL || qd == QD_NEG_RISE) return -signed'(mag);
    return signed'(mag);
  endfunction

  // port 0: sine, port 1: cosine (quarter turn ahead)
  logic [ADDR_W-1:0]       rd_addr [2];
  logic signed [AMP_W-1:0] rd_q    [2];

  assign rd_addr[0] = sin_addr_i;
  assign rd_addr[1] = sin_addr_i + ADDR_W'(QN);

  for (genvar p = 0; p < 2; p++) begin : g_port
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   rd_q[p] <= '0;
      else if (en_i) rd_q[p] <= fold(rd_addr[p]);
    end
  end

  assign sin_o = rd_q[0];
  assign cos_o = rd_q[1];

endmodule

// File: rtl/nco_product_scale.sv
module nco_product_scale #(
  parameter int IN_W  = 16,
  parameter int AMP_W = 16,
  parameter int OUT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    mul_en_i,
  input  logic                    rnd_en_i,
  input  logic signed [IN_W-1:0]  smp_i,
  input  logic signed [AMP_W-1:0] coef_i,
  output logic signed [OUT_W-1:0] res_o
);

  localparam int PW = IN_W + AMP_W;
  localparam int SH = AMP_W - 1;
  localparam int RW = PW - SH + 1;

  localparam logic signed [PW:0]   HALF = (PW + 1)'(1) <<< (SH - 1);
  localparam logic signed [RW-1:0] OMAX = RW'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [RW-1:0] OMIN = -OMAX - RW'(1);

  logic signed [PW-1:0]    prod_q;
  logic signed [PW:0]      rnd;
  logic signed [RW-1:0]    shf;
  logic signed [OUT_W-1:0] sat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prod_q <= '0;
    else if (mul_en_i) prod_q <= smp_i * coef_i;
  end

  always_comb begin
    rnd = {prod_q[PW-1], prod_q} + HALF;
    shf = signed'(rnd[PW:SH]);
    if (shf > OMAX)      sat = OMAX[OUT_W-1:0];
    else if (shf < OMIN) sat = OMIN[OUT_W-1:0];
    else                 sat = shf[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       res_o <= '0;
    else if (rnd_en_i) res_o <= sat;
  end

endmodule

// File: rtl/quad_nco_mixer.sv
module quad_nco_mixer #(
  parameter int          IN_W      = 16,
  parameter int          OUT_W     = 16,
  parameter int          AMP_W     = 16,
  parameter int          PHASE_W   = 32,
  parameter int          ADDR_W    = 10,
  parameter int unsigned CLK_HZ    = 250_000_000,
  parameter int unsigned CENTER_HZ = 70_000_000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    smp_vld_i,
  input  logic signed [IN_W-1:0]  smp_i,
  input  logic                    fcw_we_i,
  input  logic [PHASE_W-1:0]      fcw_i,
  output logic                    iq_vld_o,
  output logic signed [OUT_W-1:0] i_o,
  output logic signed [OUT_W-1:0] q_o
);

  localparam int         DEPTH   = 4;
  localparam logic [63:0] FCW_NUM = (64'(CENTER_HZ) << PHASE_W) + 64'(CLK_HZ / 2);
  localparam logic [63:0] FCW_DEF = FCW_NUM / 64'(CLK_HZ);

  logic [PHASE_W-1:0]      phase;
  logic [PHASE_W-1:0]      fcw_cur;
  logic [DEPTH-1:0]        vld_q;
  logic signed [IN_W-1:0]  smp1_q, smp2_q;
  logic [ADDR_W-1:0]       addr1_q;
  logic signed [AMP_W-1:0] sin2, cos2;
  logic signed [AMP_W-1:0] coef [2];
  logic signed [OUT_W-1:0] res  [2];

  nco_phase_acc #(
    .PHASE_W (PHASE_W),
    .DEF_FCW (FCW_DEF[PHASE_W-1:0])
  ) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (smp_vld_i),
    .fcw_we_i (fcw_we_i),
    .fcw_i    (fcw_i),
    .phase_o  (phase),
    .fcw_o    (fcw_cur)
  );

  // stage 1: capture sample and table address
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= '0;
      smp1_q  <= '0;
      addr1_q <= '0;
      smp2_q  <= '0;
    end else begin
      vld_q <= {vld_q[DEPTH-2:0], smp_vld_i};
      if (smp_vld_i) begin
        smp1_q  <= smp_i;
        addr1_q <= phase[PHASE_W-1 -: ADDR_W];
      end
      if (vld_q[0]) smp2_q <= smp1_q;
    end
  end

  // stage 2: shared table, both reads in the same cycle
  nco_quarter_lut #(
    .ADDR_W (ADDR_W),
    .AMP_W  (AMP_W)
  ) u_lut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (vld_q[0]),
    .sin_addr_i (addr1_q),
    .sin_o      (sin2),
    .cos_o      (cos2)
  );

  assign coef[0] = cos2;
  assign coef[1] = sin2;

  // stages 3-4: identical multiply and round per channel
  for (genvar c = 0; c < 2; c++) begin : g_ch
    nco_product_scale #(
      .IN_W  (IN_W),
      .AMP_W (AMP_W),
      .OUT_W (OUT_W)
    ) u_mul (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .mul_en_i (vld_q[1]),
      .rnd_en_i (vld_q[2]),
      .smp_i    (smp2_q),
      .coef_i   (coef[c]),
      .res_o    (res[c])
    );
  end

  assign i_o      = res[0];
  assign q_o      = res[1];
  assign iq_vld_o = vld_q[DEPTH-1];

endmodule

// File: rtl/quad_nco_mixer_chk.sv
module quad_nco_mixer_chk #(
  parameter int IN_W    = 16,
  parameter int OUT_W   = 16,
  parameter int PHASE_W = 32
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    smp_vld_i,
  input logic signed [IN_W-1:0]  smp_i,
  input logic                    fcw_we_i,
  input logic [PHASE_W-1:0]      fcw_i,
  input logic                    iq_vld_o,
  input logic signed [OUT_W-1:0] i_o,
  input logic signed [OUT_W-1:0] q_o,
  input logic [PHASE_W-1:0]      phase_i,
  input logic [PHASE_W-1:0]      fcw_cur_i
);

  logic [2:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  AST_VLD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd4) |-> (iq_vld_o == $past(smp_vld_i, 4))); // R6

  AST_PHASE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 3'd0 && !$past(smp_vld_i)) |-> $stable(phase_i)); // R2

  AST_FCW_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 3'd0 && $past(fcw_we_i)) |-> (fcw_cur_i == $past(fcw_i))); // R7

  AST_ZERO_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst == 3'd4 && iq_vld_o && $past(smp_i, 4) == '0) |-> (i_o == '0 && q_o == '0)); // R5

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst != 3'd0 && !iq_vld_o) |-> ($stable(i_o) && $stable(q_o))); // R8

endmodule

bind quad_nco_mixer quad_nco_mixer_chk #(
  .IN_W    (IN_W),
  .OUT_W   (OUT_W),
  .PHASE_W (PHASE_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .smp_vld_i (smp_vld_i),
  .smp_i     (smp_i),
  .fcw_we_i  (fcw_we_i),
  .fcw_i     (fcw_i),
  .iq_vld_o  (iq_vld_o),
  .i_o       (i_o),
  .q_o       (q_o),
  .phase_i   (phase),
  .fcw_cur_i (fcw_cur)
);

// File: tb/tb_quad_nco_mixer.sv
module tb_quad_nco_mixer;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               smp_vld_i = 1'b0;
  logic signed [15:0] smp_i = '0;
  logic               fcw_we_i = 1'b0;
  logic [31:0]        fcw_i = '0;
  logic               iq_vld_o;
  logic signed [15:0] i_o, q_o;

  always #5 clk = ~clk;

  quad_nco_mixer dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .smp_vld_i (smp_vld_i),
    .smp_i     (smp_i),
    .fcw_we_i  (fcw_we_i),
    .fcw_i     (fcw_i),
    .iq_vld_o  (iq_vld_o),
    .i_o       (i_o),
    .q_o       (q_o)
  );

  typedef struct { bit v; int i; int q; } exp_t;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string tag = "R1";
  logic [31:0] acc_m = '0;
  logic [31:0] fcw_m = 32'd1202590843;
  exp_t  hist [4];
  int    last_i = 0, last_q = 0;

  function automatic int lut_val(input int a);
    real x;
    x = 32767.0 * $sin(6.283185307179586 * (real'(a) + 0.5) / 1024.0);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  function automatic int mix(input int s, input int c);
    longint p, r;
    p = longint'(s) * longint'(c) + 64'sd16384;
    r = p >>> 15;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycle(input bit v, input int s, input bit we, input logic [31:0] f);
    exp_t e;
    int   a;
    @(negedge clk);
    chk("R6", "valid strobe", int'(iq_vld_o), int'(hist[3].v));
    if (hist[3].v) begin
      chk(tag, "I result", int'(i_o), hist[3].i);
      chk(tag, "Q result", int'(q_o), hist[3].q);
      last_i = hist[3].i;
      last_q = hist[3].q;
    end else begin
      chk("R8", "I hold", int'(i_o), last_i);
      chk("R8", "Q hold", int'(q_o), last_q);
    end
    for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
    e.v = v; e.i = 0; e.q = 0;
    if (v) begin
      a   = int'(acc_m[31:22]);
      e.i = mix(s, lut_val((a + 256) % 1024));
      e.q = mix(s, lut_val(a));
      acc_m = acc_m + fcw_m;
    end
    if (we) fcw_m = f;
    hist[0]   = e;
    smp_vld_i = v;
    smp_i     = 16'(s);
    fcw_we_i  = we;
    fcw_i     = f;
  endtask

  initial begin
    void'($urandom(32'd5823));
    for (int k = 0; k < 4; k++) begin hist[k].v = 0; hist[k].i = 0; hist[k].q = 0; end
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", int'(iq_vld_o), 0);
    chk("R1", "I in reset", int'(i_o), 0);
    chk("R1", "Q in reset", int'(q_o), 0);
    rst_ni = 1'b1;

    // R1: first sample uses phase zero; R7: default word drives the following samples
    tag = "R1";
    cycle(1, 1000, 0, '0);
    cycle(1, -1000, 0, '0);
    tag = "R7";
    for (int k = 0; k < 20; k++) cycle(1, 20000, 0, '0);

    // R7: word written on the same edge as a sample
    cycle(1, 12345, 1, 32'h0400_0000);
    for (int k = 0; k < 6; k++) cycle(1, 12345, 0, '0);
    cycle(1, -777, 1, 32'h1234_5678);
    for (int k = 0; k < 6; k++) cycle(1, -777, 0, '0);

    // R3: one address per sample walks every quadrant boundary
    tag = "R3";
    cycle(0, 0, 1, 32'h0040_0000);
    for (int k = 0; k < 1030; k++) cycle(1, 32767, 0, '0);

    // R5: full-scale and tiny samples
    tag = "R5";
    cycle(0, 0, 1, 32'h00D0_0000);
    for (int k = 0; k < 64; k++) begin
      case (k % 5)
        0: cycle(1, -32768, 0, '0);
        1: cycle(1, 32767, 0, '0);
        2: cycle(1, 0, 0, '0);
        3: cycle(1, 1, 0, '0);
        default: cycle(1, -1, 0, '0);
      endcase
    end

    // R2: gaps in the strobe and phase wrap
    tag = "R2";
    cycle(0, 0, 1, 32'hFFC0_0000);
    for (int k = 0; k < 40; k++) cycle(k % 3 == 0, 15000 - k * 300, 0, '0);
    cycle(0, 0, 1, 32'h8000_0001);
    for (int k = 0; k < 20; k++) cycle(k % 2 == 0, -9000, 0, '0);

    // R8: idle cycles with word writes, then resume
    tag = "R8";
    for (int k = 0; k < 8; k++) cycle(0, 31000, 1, 32'h0300_0000 + 32'(k));
    for (int k = 0; k < 6; k++) cycle(1, 31000, 0, '0);

    // R4: random traffic
    tag = "R4";
    for (int k = 0; k < 3000; k++) begin
      bit          v, we;
      int          s;
      logic [31:0] f;
      v  = ($urandom % 4) != 0;
      s  = int'($signed(16'($urandom)));
      we = ($urandom % 50) == 0;
      f  = $urandom;
      cycle(v, s, we, f);
    end
    for (int k = 0; k < 6; k++) cycle(0, 0, 0, '0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule